// File: doc/BRIEF.md
# Banked Flash Chip-Select and Strobe Interface

This block sits between a processor bus and an array of flash memory chips. Processor reads and writes that fall in the upper half of the address space (top address bit set, a 32K-word window) are turned into active-low chip enables, per-bank output-enable and write-enable strobes, and a set of high flash address bits. Two page latches hold the high address. One serves data reads from the window. The other serves data writes and program fetches from the window. Software loads both latches and a control register through a small configuration port.

The block has two modes. In random mode, bits 7:5 of the selected page latch pick one of eight chips in an interleaved order, and bit 8 picks the bank whose strobe fires. In sequential mode, meant for command/address style flash, the read latch alone picks the chip. A chip enable is driven only while a gate bit allows it, and latch bits 4 and 3 drive the command-latch and address-latch pins directly. The control register also sets the write strobe width, the data bus polarity and the per-bank deep power-down outputs. It reports the synchronised ready/busy input.

Top module: `flash_bank_if`

## Requirements
- R1: Reset state: all chip enables and strobes high, command/address-latch pins low, page output zero, both page latches zero, control register reading 8Ah while the ready input is low. Control bits: 7 keeps bank 0 powered, 6 ready (read only), 5 true polarity, 4 sequential bank, 3 keeps bank 1 powered, 2 chip-enable gate, 1 sequential mode, 0 wide write strobe. Configuration addresses: 0 read latch, 1 write latch, 2 control register.
- R2: In random mode, page bits 7:5 select chip enable 0,2,4,6,1,3,5,7 for the values 0 through 7. The read latch is used for data reads. The write latch is used for writes and for reads with the program-fetch flag set.
- R3: Exactly one bank strobe fires. In random mode its bank is page bit 8. In sequential mode its bank is control bit 4. Index 0 of the strobe outputs is bank 0.
- R4: Chip enables go active on the first clock edge that samples an in-window request. The read strobe goes active one edge later and stays active while the request is held. Everything returns inactive on the first edge after the request drops. Consecutive accesses are separated by at least one idle cycle.
- R5: The write strobe is active for 1 clock when control bit 0 is 0, and for 2 clocks when it is 1, starting one edge after the chip enable, even if the write request is held longer.
- R6: Requests with the top address bit clear leave all chip enables and strobes inactive.
- R7: In sequential mode a chip enable is driven only while control bit 2 is set, using read latch bits 7:5 for reads and writes. The command-latch and address-latch pins follow read latch bits 4 and 3. In random mode both pins are low.
- R8: With control bit 5 at 0, the data bus is inverted in both directions. With it at 1, data passes unchanged.
- R9: Control bit 6 reads the ready/busy input after SYNC_STAGES clock edges (1 means ready). Writes to bit 6 have no effect.
- R10: Power-down output n is the control bit that keeps bank n powered (bit 7 for bank 0, bit 3 for bank 1). While that output is low, no write strobe fires on bank n.
- R11: During an in-window access in random mode, the page output carries the selected latch, one edge after the request. It is zero otherwise and in sequential mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | ADDR_W | Processor address |
| cpu_rd | input | 1 | Processor read request, held for the access |
| cpu_wr | input | 1 | Processor write request, held for the access (wins over read) |
| cpu_prog | input | 1 | Read is a program fetch (uses the write latch) |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_rdata | output | DATA_W | Flash data returned to the processor |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | PAGE_W | Configuration write data |
| cfg_rdata | output | PAGE_W | Configuration read data |
| fl_ce_n | output | NUM_CE | Active-low chip enables |
| fl_oe_n | output | 2 | Active-low read strobes, one per bank |
| fl_we_n | output | 2 | Active-low write strobes, one per bank |
| fl_fa | output | PAGE_W | High flash address bits |
| fl_cle | output | 1 | Command-latch pin (sequential mode) |
| fl_ale | output | 1 | Address-latch pin (sequential mode) |
| fl_pd_n | output | 2 | Active-low deep power-down, one per bank |
| fl_rdy | input | 1 | Flash ready (1) / busy (0) |
| fl_dq_out | output | DATA_W | Data toward the flash |
| fl_dq_in | input | DATA_W | Data from the flash |

## Verification
The bench walks all eight chip-select codes to catch a plain binary decode. It mixes data reads, writes and program fetches so that a design using the wrong page latch drives the wrong chip or the wrong page output. It samples the write strobe on both cycles after the chip enable: a design ignoring the width bit, or letting the strobe follow the held request, shows a wrong level on the second cycle. Random control values cover sequential mode with the gate bit clear, writes into a powered-down bank and requests outside the window, where a faulty design would still assert an enable or strobe. It also checks the ready bit lag and that writes to that bit have no effect.

// File: rtl/fbi_pkg.sv
package fbi_pkg;

   // Control register layout; bit 6 is the read-only ready slot.
   typedef struct packed {
      logic pd0_off;   // 7: keep bank 0 powered
      logic rdy;       // 6: ready slot, never stored
      logic true_pol;  // 5: 1 = data not inverted
      logic seq_bank;  // 4: bank in sequential mode
      logic pd1_off;   // 3: keep bank 1 powered
      logic ce_en;     // 2: chip-enable gate in sequential mode
      logic seq_mode;  // 1: sequential mode
      logic wide_we;   // 0: two-clock write strobe
   } ctl_t;

   localparam logic [7:0] CTL_RESET = 8'h8A;

   localparam logic [1:0] SEL_RD  = 2'd0;
   localparam logic [1:0] SEL_WR  = 2'd1;
   localparam logic [1:0] SEL_CTL = 2'd2;

   // Interleaved chip mapping: low two select bits step by two, top bit adds one.
   function automatic logic [2:0] ce_index(input logic [2:0] sel);
      return {sel[1:0], sel[2]};
   endfunction

endpackage

// File: rtl/fbi_regs.sv
module fbi_regs
   import fbi_pkg::*;
#(
   parameter int PAGE_W      = 10,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_addr,
   input  logic [PAGE_W-1:0] cfg_wdata,
   input  logic              fl_rdy,
   output logic [PAGE_W-1:0] rd_page,
   output logic [PAGE_W-1:0] wr_page,
   output ctl_t              ctl,
   output logic [PAGE_W-1:0] cfg_rdata
);

   if (PAGE_W < 10) begin : g_bad_page
      $error("PAGE_W must cover latch bits 9:0");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("SYNC_STAGES must be 0 to 4");
   end

   ctl_t              ctl_q;
   logic [PAGE_W-1:0] rd_q, wr_q;
   logic              rdy_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q  <= '0;
         wr_q  <= '0;
         ctl_q <= ctl_t'(CTL_RESET);
      end else if (cfg_we) begin
         case (cfg_addr)
            SEL_RD:  rd_q <= cfg_wdata;
            SEL_WR:  wr_q <= cfg_wdata;
            SEL_CTL: begin
               ctl_q     <= ctl_t'(cfg_wdata[7:0]);
               ctl_q.rdy <= 1'b0;
            end
            default: ;
         endcase
      end
   end

   if (SYNC_STAGES == 0) begin : g_nosync
      assign rdy_s = fl_rdy;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] st;
      for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      st[i] <= 1'b0;
            else if (i == 0) st[i] <= fl_rdy;
            else             st[i] <= st[(i == 0) ? 0 : i-1];
         end
      end
      assign rdy_s = st[SYNC_STAGES-1];
   end

   always_comb begin
      cfg_rdata = '0;
      case (cfg_addr)
         SEL_RD:  cfg_rdata = rd_q;
         SEL_WR:  cfg_rdata = wr_q;
         SEL_CTL: cfg_rdata[7:0] = {ctl_q.pd0_off, rdy_s, ctl_q[5:0]};
         default: cfg_rdata = '0;
      endcase
   end

   assign rd_page = rd_q;
   assign wr_page = wr_q;
   assign ctl     = ctl_q;

   // R9: a control write never stores the ready slot
   p_rdy_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == SEL_CTL && cfg_wdata[6]) |=> (ctl_q.rdy == 1'b0));

   // R1: a latch write lands on the next edge
   p_latch_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == SEL_RD) |=> (rd_page == $past(cfg_wdata)));

endmodule

// File: rtl/fbi_decode.sv
module fbi_decode
   import fbi_pkg::*;
#(
   parameter int PAGE_W = 10,
   parameter int NUM_CE = 8
) (
   input  logic              req,
   input  logic [PAGE_W-1:0] page,
   input  logic              seq_mode,
   input  logic              ce_en,
   input  logic              seq_bank,
   output logic [NUM_CE-1:0] ce_n_nx,
   output logic              bank
);

   if (NUM_CE != 8) begin : g_bad_ce
      $error("NUM_CE must be 8 for the three-bit interleaved select");
   end

   localparam int SEL_LSB = 5;

   logic [2:0] sel;
   assign sel = page[SEL_LSB+2:SEL_LSB];

   always_comb begin
      ce_n_nx = '1;
      if (req && (!seq_mode || ce_en))
         ce_n_nx[ce_index(sel)] = 1'b0;
   end

   assign bank = seq_mode ? seq_bank : page[8];

endmodule

// File: rtl/fbi_strobe.sv
module fbi_strobe #(
   parameter int NUM_CE = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_req,
   input  logic              wr_req,
   input  logic              bank,
   input  logic              wide_we,
   input  logic [1:0]        pd_n,
   input  logic [NUM_CE-1:0] ce_n_nx,
   output logic [NUM_CE-1:0] ce_n,
   output logic [1:0]        oe_n,
   output logic [1:0]        we_n
);

   localparam int AGE_W   = 2;
   localparam logic [AGE_W-1:0] AGE_MAX = '1;

   logic [AGE_W-1:0] age;
   logic             we_on;

   assign we_on = wr_req && pd_n[bank] &&
                  (age == 2'd1 || (wide_we && age == 2'd2));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         age  <= '0;
         ce_n <= '1;
         oe_n <= '1;
         we_n <= '1;
      end else begin
         if (rd_req || wr_req) age <= (age == AGE_MAX) ? AGE_MAX : age + 1'b1;
         else                  age <= '0;
         ce_n <= ce_n_nx;
         oe_n <= '1;
         we_n <= '1;
         if (rd_req && age != '0) oe_n[bank] <= 1'b0;
         if (we_on)               we_n[bank] <= 1'b0;
      end
   end

   // R2: at most one chip enable active
   p_ce_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~ce_n));

   // R3: at most one strobe of either kind on either bank
   p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({~oe_n, ~we_n}));

   // R5: write strobe never lasts three clocks
   p_we_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((we_n != 2'b11) && $past(we_n != 2'b11)) |-> !$past(we_n != 2'b11, 2));

   // R10: a powered-down bank gets no write strobe
   p_pd_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (we_n[0] == 1'b0) |-> $past(pd_n[0]));

endmodule

// File: rtl/flash_bank_if.sv
module flash_bank_if
   import fbi_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 16,
   parameter int PAGE_W      = 10,
   parameter int NUM_CE      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              cpu_rd,
   input  logic              cpu_wr,
   input  logic              cpu_prog,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_addr,
   input  logic [PAGE_W-1:0] cfg_wdata,
   output logic [PAGE_W-1:0] cfg_rdata,
   output logic [NUM_CE-1:0] fl_ce_n,
   output logic [1:0]        fl_oe_n,
   output logic [1:0]        fl_we_n,
   output logic [PAGE_W-1:0] fl_fa,
   output logic              fl_cle,
   output logic              fl_ale,
   output logic [1:0]        fl_pd_n,
   input  logic              fl_rdy,
   output logic [DATA_W-1:0] fl_dq_out,
   input  logic [DATA_W-1:0] fl_dq_in
);

   localparam int WIN_BIT = ADDR_W - 1;

   logic [PAGE_W-1:0] rd_page, wr_page, page;
   ctl_t              ctl;
   logic              req, rd_req, wr_req, use_wr, bank;
   logic [NUM_CE-1:0] ce_n_nx;
   logic [DATA_W-1:0] pol_mask;

   fbi_regs #(.PAGE_W(PAGE_W), .SYNC_STAGES(SYNC_STAGES)) u_regs (
      .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .fl_rdy,
      .rd_page, .wr_page, .ctl, .cfg_rdata
   );

   assign req    = cpu_addr[WIN_BIT] && (cpu_rd || cpu_wr);
   assign wr_req = req && cpu_wr;
   assign rd_req = req && cpu_rd && !cpu_wr;
   assign use_wr = !ctl.seq_mode && (cpu_wr || (cpu_rd && cpu_prog));
   assign page   = use_wr ? wr_page : rd_page;

   fbi_decode #(.PAGE_W(PAGE_W), .NUM_CE(NUM_CE)) u_dec (
      .req, .page, .seq_mode(ctl.seq_mode), .ce_en(ctl.ce_en),
      .seq_bank(ctl.seq_bank), .ce_n_nx, .bank
   );

   assign fl_pd_n = {ctl.pd1_off, ctl.pd0_off};

   fbi_strobe #(.NUM_CE(NUM_CE)) u_stb (
      .clk, .rst_n, .rd_req, .wr_req, .bank, .wide_we(ctl.wide_we),
      .pd_n(fl_pd_n), .ce_n_nx, .ce_n(fl_ce_n), .oe_n(fl_oe_n), .we_n(fl_we_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fl_fa  <= '0;
         fl_cle <= 1'b0;
         fl_ale <= 1'b0;
      end else begin
         fl_fa  <= (req && !ctl.seq_mode) ? page : '0;
         fl_cle <= ctl.seq_mode && rd_page[4];
         fl_ale <= ctl.seq_mode && rd_page[3];
      end
   end

   assign pol_mask  = {DATA_W{!ctl.true_pol}};
   assign fl_dq_out = cpu_wdata ^ pol_mask;
   assign cpu_rdata = fl_dq_in ^ pol_mask;

   // R6: an idle or out-of-window cycle leaves every enable and strobe off
   p_outside_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!req) |-> (fl_ce_n == '1 && fl_oe_n == 2'b11 && fl_we_n == 2'b11));

   // R4: in random mode a strobe is preceded by an active chip enable
   p_ce_leads_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl.seq_mode && $past(!ctl.seq_mode) && (fl_oe_n != 2'b11 || fl_we_n != 2'b11))
      |-> $past(fl_ce_n != '1));

   // R7: latch pins stay low outside sequential mode
   p_cle_random_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!ctl.seq_mode) |-> (!fl_cle && !fl_ale));

endmodule

// File: tb/tb_flash_bank_if.sv
module tb_flash_bank_if;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic        cpu_rd = 1'b0, cpu_wr = 1'b0, cpu_prog = 1'b0;
   logic [15:0] cpu_wdata = '0, fl_dq_in = '0;
   logic [15:0] cpu_rdata, fl_dq_out;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_addr = '0;
   logic [9:0]  cfg_wdata = '0, cfg_rdata, fl_fa;
   logic [7:0]  fl_ce_n;
   logic [1:0]  fl_oe_n, fl_we_n, fl_pd_n;
   logic        fl_cle, fl_ale;
   logic        fl_rdy = 1'b0;

   int checks = 0, errors = 0;
   bit done = 0;
   logic [9:0] m_rd = '0, m_wr = '0;
   logic [7:0] m_ctl = 8'h8A;

   always #(CLK_PERIOD/2) clk = ~clk;

   flash_bank_if dut (
      .clk, .rst_n, .cpu_addr, .cpu_rd, .cpu_wr, .cpu_prog, .cpu_wdata, .cpu_rdata,
      .cfg_we, .cfg_addr, .cfg_wdata, .cfg_rdata, .fl_ce_n, .fl_oe_n, .fl_we_n,
      .fl_fa, .fl_cle, .fl_ale, .fl_pd_n, .fl_rdy, .fl_dq_out, .fl_dq_in
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_ce(input logic [2:0] sel);
      return ~(8'd1 << {sel[1:0], sel[2]});
   endfunction

   task automatic cfg_write(input logic [1:0] a, input logic [9:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      if (a == 2'd0) m_rd = d;
      if (a == 2'd1) m_wr = d;
      if (a == 2'd2) m_ctl = d[7:0] & 8'hBF;
   endtask

   // kind: 0 data read, 1 write, 2 program fetch, 3 outside read, 4 outside write
   task automatic do_access(input int kind);
      logic [15:0] a;
      logic        seq, inwin, isrd, iswr, bank, pd_ok;
      logic [9:0]  page;
      logic [7:0]  ce_e;
      logic [1:0]  strb;
      a     = (kind >= 3) ? (16'($urandom) & 16'h7FFF) : (16'($urandom) | 16'h8000);
      seq   = m_ctl[1];
      inwin = (kind < 3);
      isrd  = (kind == 0 || kind == 2 || kind == 3);
      iswr  = (kind == 1 || kind == 4);
      page  = (!seq && (kind == 1 || kind == 2)) ? m_wr : m_rd;
      bank  = seq ? m_ctl[4] : page[8];
      pd_ok = bank ? m_ctl[3] : m_ctl[7];
      ce_e  = (inwin && (!seq || m_ctl[2])) ? exp_ce(page[7:5]) : 8'hFF;
      strb  = ~(2'b01 << bank);
      @(negedge clk);
      cpu_addr = a; cpu_rd = isrd; cpu_wr = iswr; cpu_prog = (kind == 2);
      @(negedge clk);   // one edge: enables and page out, strobes still off
      chk(inwin ? "R2 chip enable" : "R6 chip enable outside", fl_ce_n, ce_e);
      chk("R11 page output", fl_fa, (inwin && !seq) ? page : 10'd0);
      chk("R4 no early strobe", {fl_oe_n, fl_we_n}, 4'hF);
      chk("R7 latch pins", {fl_cle, fl_ale}, seq ? {m_rd[4], m_rd[3]} : 2'b00);
      @(negedge clk);   // second edge: strobe on
      chk(inwin && isrd ? "R3 read strobe" : "R6 read strobe", fl_oe_n,
          (inwin && isrd) ? strb : 2'b11);
      chk(inwin && iswr ? "R10 write strobe" : "R6 write strobe", fl_we_n,
          (inwin && iswr && pd_ok) ? strb : 2'b11);
      @(negedge clk);   // third edge: read held, write only if wide
      chk("R4 read held", fl_oe_n, (inwin && isrd) ? strb : 2'b11);
      chk("R5 write width", fl_we_n, (inwin && iswr && pd_ok && m_ctl[0]) ? strb : 2'b11);
      cpu_rd = 1'b0; cpu_wr = 1'b0; cpu_prog = 1'b0;
      @(negedge clk);
      chk("R4 release", {fl_ce_n, fl_oe_n, fl_we_n}, 12'hFFF);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 enables", fl_ce_n, 8'hFF);
      chk("R1 strobes", {fl_oe_n, fl_we_n}, 4'hF);
      chk("R1 latch pins and page", {fl_cle, fl_ale, fl_fa}, 12'h000);
      rst_n = 1'b1;
      @(negedge clk);
      cfg_addr = 2'd2; #1;
      chk("R1 control reset", cfg_rdata, 10'h08A);
      chk("R1 power-down outputs", fl_pd_n, 2'b11);
      cfg_addr = 2'd0; #1; chk("R1 read latch reset", cfg_rdata, 10'h000);
      cfg_addr = 2'd1; #1; chk("R1 write latch reset", cfg_rdata, 10'h000);

      // R7: reset is sequential mode with the gate clear, so no enable
      do_access(0);

      // R2 all eight codes in random mode, narrow strobe
      cfg_write(2'd2, 10'h0A8);
      for (int s = 0; s < 8; s++) begin
         cfg_write(2'd0, 10'(s << 5) | 10'h100);
         cfg_write(2'd1, 10'(s << 5));
         do_access(0);
         do_access(1);
      end
      // R5 wide strobe, R10 bank 1 powered down
      cfg_write(2'd2, 10'h0A1);
      cfg_write(2'd1, 10'h1E0);
      do_access(1);
      cfg_write(2'd1, 10'h0E0);
      do_access(1);

      // R8 polarity
      cpu_wdata = 16'h1234; fl_dq_in = 16'hA5C3;
      cfg_write(2'd2, 10'h088); #1;
      chk("R8 inverted out", fl_dq_out, 32'h0000EDCB);
      chk("R8 inverted in", cpu_rdata, 32'h00005A3C);
      cfg_write(2'd2, 10'h0A8); #1;
      chk("R8 true out", fl_dq_out, 32'h00001234);
      chk("R8 true in", cpu_rdata, 32'h0000A5C3);

      // R9 ready lag and write-ignore
      cfg_addr = 2'd2;
      fl_rdy = 1'b1;
      @(negedge clk); chk("R9 ready after one edge", cfg_rdata[6], 1'b0);
      @(negedge clk); chk("R9 ready after two edges", cfg_rdata[6], 1'b1);
      fl_rdy = 1'b0;
      repeat (3) @(negedge clk);
      cfg_write(2'd2, 10'h0E8);
      cfg_addr = 2'd2; #1;
      chk("R9 ready write ignored", cfg_rdata, 10'h0A8);

      // random mix
      for (int i = 0; i < 120; i++) begin
         if (i % 4 == 0) begin
            cfg_write(2'd0, 10'($urandom));
            cfg_write(2'd1, 10'($urandom));
            cfg_write(2'd2, 10'($urandom) & 10'h0BF);
         end
         do_access(int'($urandom_range(0, 4)));
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule